// File: doc/BRIEF.md
# Overcurrent Trip-Level Calibration Sequencer

This block runs once after the supply comes up and learns the overcurrent trip level that a converter's protection logic will use from then on. When the supply-good input goes high, it turns on a small test current out of the threshold-setting pin. An external resistor on that pin turns the current into a voltage. After a short settling interval the block walks a reference DAC upward in equal steps, holding each step for a fixed dwell. At the end of each dwell it samples a comparator that reports whether the DAC has reached the pin voltage. The first code that reaches it is latched as the trip level.

If the pin voltage climbs to the clamp level (no resistor fitted), a second comparator fires and the search stops at once. A fixed default level is latched instead. If the ramp runs out of codes without a compare, the top code is kept. At the end the test current is switched off and a done flag is raised. The flag gates the start of soft-start together with the supply-good input. The latched level survives any later supply dips and is cleared only by reset, which stands for a full power cycle.

The DAC code has a 5 mV LSB. The ramp runs from code 10 (50 mV) to code 110 (550 mV) in steps of 2 codes (10 mV), which gives 51 steps. The fixed default is code 75 (375 mV). The dwell and settle lengths are parameters. Their defaults size the full sweep to about 9 ms at a 10 MHz clock.

Top module: `ocp_cal_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, isrc_en, cal_done and ss_enable are 0, trip_code is 0 and dac_code is 10.
- R2: With no calibration done and the test current off, a high uvlo_ok turns isrc_en on at the next clock edge. The current then stays on for SETTLE_CYC cycles before the first compare, and for the whole ramp after that.
- R3: dac_code starts each sweep at 10 and rises by exactly 2 after every DWELL_CYC cycles. It never leaves the range 10 to 110.
- R4: If cmp_reached is high on the last cycle of a dwell, the current dac_code is latched into trip_code and cal_done rises on the next edge. A pin voltage below 50 mV therefore gives code 10.
- R5: If the dwell at code 110 ends without cmp_reached, trip_code becomes 110 and cal_done rises.
- R6: clamp_hit while the test current is on ends calibration on the next edge with trip_code = 75, whatever the compare flag and ramp position are.
- R7: uvlo_ok falling while the test current is on turns isrc_en off on the next edge without setting cal_done. dac_code returns to 10 before the current is turned on again, and a full calibration restarts when uvlo_ok returns.
- R8: Once cal_done is 1 it stays 1, isrc_en stays 0 and trip_code does not change, whatever uvlo_ok, cmp_reached and clamp_hit do, until reset.
- R9: ss_enable is 1 exactly when cal_done is 1 and uvlo_ok is 1.
- R10: The test current is never on for more than SETTLE_CYC + 51*DWELL_CYC cycles in a row. With no compare and no clamp, cal_done is seen that many cycles plus one after uvlo_ok rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| uvlo_ok | input | 1 | Supply above undervoltage threshold |
| cmp_reached | input | 1 | DAC voltage has reached the set-pin voltage |
| clamp_hit | input | 1 | Set-pin voltage at clamp level (no resistor) |
| isrc_en | output | 1 | Enables the test current out of the set pin |
| dac_code | output | CODE_W | Reference DAC code, 5 mV per LSB |
| trip_code | output | CODE_W | Latched overcurrent trip level, same scale |
| cal_done | output | 1 | Calibration finished, level valid |
| ss_enable | output | 1 | Soft-start may run |

## Verification
The assertions watch the step size and range of the DAC ramp, the start of the test current, the clamp's immediate end with the default code, the abort on supply loss, the stickiness of the done state and latched level, and the upper bound on how long the test current stays on. Only the bench's scenarios can show that the correct code is latched for a given pin voltage: below the span, mid-span, above the span with no clamp, and clamp. The same holds for the exact completion time of a full and a partial sweep, the restart after a supply dip, and that forced comparator activity after completion changes nothing. A behavioural model compares every output on every clock.

// File: rtl/ocp_cal_pkg.sv
// Shared types for the overcurrent calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ocp_cal_pkg;

    // Sequencer phases, in order of progress.
    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_SETTLE = 2'd1,
        CAL_STEP   = 2'd2,
        CAL_DONE   = 2'd3
    } cal_state_e;

    // What the level register should take on this edge.
    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_DAC   = 2'd1,
        CAP_FIXED = 2'd2
    } cap_sel_e;

endpackage

// File: rtl/ocp_cal_timer.sv
// Cycle timer: while run is high, counts MAX_CYC cycles and pulses tick
// on the last one, then wraps. Clears whenever run is low.
// Assumes: MAX_CYC >= 1.
module ocp_cal_timer #(
    parameter int unsigned MAX_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_CYC - 1);

    logic [CW-1:0] cnt;

    // Count cycles of the running interval, wrapping on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final cycle of the interval.
    always_comb begin
        tick = run && (cnt == LAST);
    end
endmodule

// File: rtl/ocp_cal_ramp.sv
// Staircase code generator: restarts at CODE_LO, rises by CODE_STEP on
// each advance, and stops at CODE_HI.
// Assumes: (CODE_HI - CODE_LO) is a multiple of CODE_STEP.
module ocp_cal_ramp #(
    parameter int unsigned CODE_W    = 7,
    parameter int unsigned CODE_LO   = 10,
    parameter int unsigned CODE_HI   = 110,
    parameter int unsigned CODE_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [CODE_W-1:0] dac_code,
    output logic              at_top
);
    localparam logic [CODE_W-1:0] LO_C   = CODE_W'(CODE_LO);
    localparam logic [CODE_W-1:0] HI_C   = CODE_W'(CODE_HI);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(CODE_STEP);

    // Hold, restart or step the DAC code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= LO_C;
        end else if (restart) begin
            dac_code <= LO_C;
        end else if (advance && !at_top) begin
            dac_code <= dac_code + STEP_C;
        end
    end

    // Report that the last code of the span is on the DAC.
    always_comb begin
        at_top = (dac_code >= HI_C);
    end
endmodule

// File: rtl/ocp_cal_store.sv
// Trip-level register: loads the live DAC code or the fixed default
// when told to, otherwise holds. Only reset clears it.
// Assumes: FIXED_CODE fits in CODE_W bits.
module ocp_cal_store
    import ocp_cal_pkg::*;
#(
    parameter int unsigned CODE_W     = 7,
    parameter int unsigned FIXED_CODE = 75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_sel_e          cap_sel,
    input  logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] trip_code
);
    localparam logic [CODE_W-1:0] FIX_C = CODE_W'(FIXED_CODE);

    // Latch the selected level; keep it until power is cycled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_code <= '0;
        end else begin
            case (cap_sel)
                CAP_DAC:   trip_code <= dac_code;
                CAP_FIXED: trip_code <= FIX_C;
                default:   trip_code <= trip_code;
            endcase
        end
    end
endmodule

// File: rtl/ocp_cal_fsm.sv
// Calibration control: waits for supply-good, settles the test current,
// walks the ramp, and decides which level to latch. Priority on each
// cycle: supply loss, then clamp, then compare, then top of ramp.
// Assumes: inputs are synchronous to clk.
module ocp_cal_fsm
    import ocp_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_ok,
    input  logic       cmp_reached,
    input  logic       clamp_hit,
    input  logic       settle_tick,
    input  logic       dwell_tick,
    input  logic       at_top,
    output cal_state_e state,
    output logic       ramp_restart,
    output logic       ramp_adv,
    output cap_sel_e   cap_sel
);
    cal_state_e nxt;

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAL_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Decide the next phase, ramp action and capture selection.
    always_comb begin
        nxt      = state;
        ramp_adv = 1'b0;
        cap_sel  = CAP_HOLD;
        case (state)
            CAL_IDLE: begin
                if (uvlo_ok) begin
                    nxt = CAL_SETTLE;
                end
            end
            CAL_SETTLE: begin
                if (!uvlo_ok) begin
                    nxt = CAL_IDLE;
                end else if (clamp_hit) begin
                    nxt     = CAL_DONE;
                    cap_sel = CAP_FIXED;
                end else if (settle_tick) begin
                    nxt = CAL_STEP;
                end
            end
            CAL_STEP: begin
                if (!uvlo_ok) begin
                    nxt = CAL_IDLE;
                end else if (clamp_hit) begin
                    nxt     = CAL_DONE;
                    cap_sel = CAP_FIXED;
                end else if (dwell_tick) begin
                    if (cmp_reached || at_top) begin
                        nxt     = CAL_DONE;
                        cap_sel = CAP_DAC;
                    end else begin
                        ramp_adv = 1'b1;
                    end
                end
            end
            default: begin
                nxt = CAL_DONE;
            end
        endcase
    end

    // Keep the ramp parked at its first code until stepping begins.
    always_comb begin
        ramp_restart = (state == CAL_IDLE) || (state == CAL_SETTLE);
    end
endmodule

// File: rtl/ocp_cal_seq.sv
// Top of the overcurrent calibration sequencer. Ties the control, the
// two interval timers, the DAC ramp and the level register together and
// derives the pin-current enable, done flag and soft-start gate.
// Assumes: rst_n is asserted on every power-up; all inputs synchronous.
module ocp_cal_seq
    import ocp_cal_pkg::*;
#(
    parameter int unsigned CODE_W     = 7,
    parameter int unsigned CODE_LO    = 10,
    parameter int unsigned CODE_HI    = 110,
    parameter int unsigned CODE_STEP  = 2,
    parameter int unsigned FIXED_CODE = 75,
    parameter int unsigned SETTLE_CYC = 200,
    parameter int unsigned DWELL_CYC  = 1764
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_ok,
    input  logic              cmp_reached,
    input  logic              clamp_hit,
    output logic              isrc_en,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] trip_code,
    output logic              cal_done,
    output logic              ss_enable
);
    cal_state_e state;
    logic       ramp_restart;
    logic       ramp_adv;
    cap_sel_e   cap_sel;
    logic       settle_tick;
    logic       dwell_tick;
    logic       at_top;

    ocp_cal_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_ok      (uvlo_ok),
        .cmp_reached  (cmp_reached),
        .clamp_hit    (clamp_hit),
        .settle_tick  (settle_tick),
        .dwell_tick   (dwell_tick),
        .at_top       (at_top),
        .state        (state),
        .ramp_restart (ramp_restart),
        .ramp_adv     (ramp_adv),
        .cap_sel      (cap_sel)
    );

    ocp_cal_timer #(.MAX_CYC(SETTLE_CYC)) u_settle_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == CAL_SETTLE),
        .tick  (settle_tick)
    );

    ocp_cal_timer #(.MAX_CYC(DWELL_CYC)) u_dwell_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == CAL_STEP),
        .tick  (dwell_tick)
    );

    ocp_cal_ramp #(
        .CODE_W    (CODE_W),
        .CODE_LO   (CODE_LO),
        .CODE_HI   (CODE_HI),
        .CODE_STEP (CODE_STEP)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (ramp_restart),
        .advance  (ramp_adv),
        .dac_code (dac_code),
        .at_top   (at_top)
    );

    ocp_cal_store #(
        .CODE_W     (CODE_W),
        .FIXED_CODE (FIXED_CODE)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_sel   (cap_sel),
        .dac_code  (dac_code),
        .trip_code (trip_code)
    );

    // Derive pin current, completion and soft-start gating from the phase.
    always_comb begin
        isrc_en   = (state == CAL_SETTLE) || (state == CAL_STEP);
        cal_done  = (state == CAL_DONE);
        ss_enable = cal_done && uvlo_ok;
    end
endmodule

// File: rtl/ocp_cal_seq_chk.sv
// Property checker for ocp_cal_seq, attached by bind below.
// Assumes: same parameters as the bound instance.
module ocp_cal_seq_chk #(
    parameter int unsigned CODE_W     = 7,
    parameter int unsigned CODE_LO    = 10,
    parameter int unsigned CODE_HI    = 110,
    parameter int unsigned CODE_STEP  = 2,
    parameter int unsigned FIXED_CODE = 75,
    parameter int unsigned SETTLE_CYC = 200,
    parameter int unsigned DWELL_CYC  = 1764
) (
    input logic              clk,
    input logic              rst_n,
    input logic              uvlo_ok,
    input logic              clamp_hit,
    input logic              isrc_en,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] trip_code,
    input logic              cal_done
);
    localparam int unsigned NSTEP = (CODE_HI - CODE_LO) / CODE_STEP + 1;
    localparam int unsigned LIMIT = SETTLE_CYC + NSTEP * DWELL_CYC;

    logic [31:0] on_cnt;

    // Length of the current run of test-current cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_cnt <= '0;
        end else if (isrc_en) begin
            on_cnt <= on_cnt + 1'b1;
        end else begin
            on_cnt <= '0;
        end
    end

    // R2
    r2_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isrc_en && !cal_done && uvlo_ok) |=> isrc_en);

    // R3
    r3_step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isrc_en && $past(isrc_en) && (dac_code != $past(dac_code)))
        |-> (dac_code == $past(dac_code) + CODE_W'(CODE_STEP)));

    // R3
    r3_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code >= CODE_W'(CODE_LO)) && (dac_code <= CODE_W'(CODE_HI)));

    // R6
    r6_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isrc_en && uvlo_ok && clamp_hit)
        |=> (cal_done && (trip_code == CODE_W'(FIXED_CODE))));

    // R7
    r7_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isrc_en && !uvlo_ok) |=> (!isrc_en && !cal_done));

    // R8
    r8_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (cal_done && !isrc_en && $stable(trip_code)));

    // R10
    r10_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_cnt <= 32'(LIMIT));
endmodule

bind ocp_cal_seq ocp_cal_seq_chk #(
    .CODE_W     (CODE_W),
    .CODE_LO    (CODE_LO),
    .CODE_HI    (CODE_HI),
    .CODE_STEP  (CODE_STEP),
    .FIXED_CODE (FIXED_CODE),
    .SETTLE_CYC (SETTLE_CYC),
    .DWELL_CYC  (DWELL_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uvlo_ok   (uvlo_ok),
    .clamp_hit (clamp_hit),
    .isrc_en   (isrc_en),
    .dac_code  (dac_code),
    .trip_code (trip_code),
    .cal_done  (cal_done)
);

// File: tb/ocp_cal_seq_bench.sv
// Bench for ocp_cal_seq: a behavioural model, compared on every clock,
// plus scenario checks on the latched level and timing.
module ocp_cal_seq_bench;
    localparam int CW     = 7;
    localparam int LO     = 10;
    localparam int HI     = 110;
    localparam int STEP   = 2;
    localparam int FIX    = 75;
    localparam int SETTLE = 5;
    localparam int DWELL  = 4;
    localparam int NSTEP  = (HI - LO) / STEP + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          uvlo_ok = 1'b0;
    logic          cmp_reached;
    logic          clamp_hit;
    logic          isrc_en;
    logic [CW-1:0] dac_code;
    logic [CW-1:0] trip_code;
    logic          cal_done;
    logic          ss_enable;

    int  pin_mv = 233;
    bit  frc_cmp = 1'b0;
    bit  frc_clamp = 1'b0;
    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;

    // model state
    int  m_st = 0;
    int  m_cnt = 0;
    int  m_dac = LO;
    int  m_trip = 0;
    bit  m_isrc = 1'b0;

    always #5 clk = ~clk;

    // Analog stand-in: pin voltage from the test current, compared with the DAC.
    assign cmp_reached = (isrc_en && (int'(dac_code) * 5 >= pin_mv)) || frc_cmp;
    assign clamp_hit   = (isrc_en && (pin_mv >= 700)) || frc_clamp;

    ocp_cal_seq #(
        .CODE_W(CW), .CODE_LO(LO), .CODE_HI(HI), .CODE_STEP(STEP),
        .FIXED_CODE(FIX), .SETTLE_CYC(SETTLE), .DWELL_CYC(DWELL)
    ) u_ocp_cal_seq (
        .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok),
        .cmp_reached(cmp_reached), .clamp_hit(clamp_hit),
        .isrc_en(isrc_en), .dac_code(dac_code), .trip_code(trip_code),
        .cal_done(cal_done), .ss_enable(ss_enable)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_trip(input int mv);
        if (mv >= 700) return FIX;
        for (int c = LO; c <= HI; c += STEP) begin
            if (c * 5 >= mv) return c;
        end
        return HI;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit c;
        bit k;
        c = (m_isrc && (m_dac * 5 >= pin_mv)) || frc_cmp;
        k = (m_isrc && (pin_mv >= 700)) || frc_clamp;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_dac = LO; m_trip = 0;
        end else begin
            case (m_st)
                0: begin
                    m_dac = LO;
                    if (uvlo_ok) begin m_st = 1; m_cnt = 0; end
                end
                1: begin
                    if (!uvlo_ok) m_st = 0;
                    else if (k) begin m_trip = FIX; m_st = 3; end
                    else if (m_cnt == SETTLE - 1) begin m_st = 2; m_cnt = 0; end
                    else m_cnt++;
                end
                2: begin
                    if (!uvlo_ok) m_st = 0;
                    else if (k) begin m_trip = FIX; m_st = 3; end
                    else if (m_cnt == DWELL - 1) begin
                        m_cnt = 0;
                        if (c || m_dac == HI) begin m_trip = m_dac; m_st = 3; end
                        else m_dac += STEP;
                    end else m_cnt++;
                end
                default: ;
            endcase
        end
        m_isrc = (m_st == 1) || (m_st == 2);
    end

    // Compare every output with the model shortly after each edge.
    always @(posedge clk) begin
        #3;
        chk("R2 isrc_en", int'(isrc_en), int'(m_isrc));
        chk("R3 dac_code", int'(dac_code), m_dac);
        chk("R4 trip_code", int'(trip_code), m_trip);
        chk("R8 cal_done", int'(cal_done), int'(m_st == 3));
        chk("R9 ss_enable", int'(ss_enable), int'((m_st == 3) && uvlo_ok));
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic power_cycle(input int mv);
        @(negedge clk);
        rst_n = 1'b0; uvlo_ok = 1'b0; frc_cmp = 1'b0; frc_clamp = 1'b0; pin_mv = mv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_to_done(output int n);
        n = 0;
        uvlo_ok = 1'b1;
        while (!cal_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 isrc_en", int'(isrc_en), 0);
        chk("R1 cal_done", int'(cal_done), 0);
        chk("R1 ss_enable", int'(ss_enable), 0);
        chk("R1 trip_code", int'(trip_code), 0);
        chk("R1 dac_code", int'(dac_code), LO);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 idle without supply", int'(isrc_en), 0);

        // R4: mid-span resistor
        run_to_done(n);
        chk("R4 mid-span code", int'(trip_code), exp_trip(233));
        chk("R4 mid-span time", n, 1 + SETTLE + ((exp_trip(233) - LO) / STEP + 1) * DWELL);

        // R8: later activity does not recalibrate
        pin_mv = 60; frc_cmp = 1'b1; frc_clamp = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 level held", int'(trip_code), exp_trip(233));
        chk("R8 current off", int'(isrc_en), 0);
        // R9: soft-start gate follows supply
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk("R9 gate low", int'(ss_enable), 0);
        chk("R8 done held", int'(cal_done), 1);
        uvlo_ok = 1'b1;
        @(negedge clk);
        chk("R9 gate high", int'(ss_enable), 1);

        // R4: below the span -> first code
        power_cycle(40);
        run_to_done(n);
        chk("R4 lowest code", int'(trip_code), LO);

        // R5 and R10: above span, no clamp -> top code after full sweep
        power_cycle(600);
        run_to_done(n);
        chk("R5 top code", int'(trip_code), HI);
        chk("R10 full sweep time", n, 1 + SETTLE + NSTEP * DWELL);

        // R6: clamp at once
        power_cycle(800);
        run_to_done(n);
        chk("R6 fixed code", int'(trip_code), FIX);
        chk("R6 early end", n, 2);

        // R6: clamp midway through the sweep
        power_cycle(500);
        uvlo_ok = 1'b1;
        repeat (30) @(negedge clk);
        frc_clamp = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 mid-sweep clamp done", int'(cal_done), 1);
        chk("R6 mid-sweep clamp code", int'(trip_code), FIX);

        // R7: supply dip mid-sweep, then restart
        power_cycle(500);
        uvlo_ok = 1'b1;
        repeat (1 + SETTLE + DWELL) @(negedge clk);
        chk("R3 second step", int'(dac_code), LO + STEP);
        repeat (20) @(negedge clk);
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk("R7 current off", int'(isrc_en), 0);
        @(negedge clk);
        chk("R7 ramp back", int'(dac_code), LO);
        chk("R7 not done", int'(cal_done), 0);
        repeat (3) @(negedge clk);
        run_to_done(n);
        chk("R7 restart code", int'(trip_code), exp_trip(500));
        chk("R7 restart time", n, 1 + SETTLE + ((exp_trip(500) - LO) / STEP + 1) * DWELL);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule